// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers level-sensitive interrupt requests from up to 32 peripheral sources and turns them into two processor lines: a fast-interrupt line and an ordinary IRQ line. Each source is gated by an enable mask. A per-source class bit sends it either to the fast class or to the IRQ class. Inside the IRQ class, sixteen programmable slots bind chosen sources to handler addresses with a fixed ranking. Slot 0 ranks highest and slot 15 lowest. Any IRQ-class request that no enabled slot claims is non-vectored, and it ranks below every slot.

Software uses a small word-addressed register port. Through it, software sets the mask, the class bits and the slot table, and loads the handler addresses and one shared default address. It can read the raw, IRQ-class and fast-class status, and it fetches the vector address when the processor takes an IRQ.

Reading the vector address does two things when IRQ is asserted. It returns the address of the winning slot (or the default address if no slot wins), and it records the priority level now in service. While a level is in service, requests at that level or below stay off the IRQ line, but a higher slot can still raise it. Writing the vector address register ends service and drops the recorded level.

Top module: `vic_prio_ctrl`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are 0, and the enable, class, default, slot control and handler registers all read 0.
- R2: Register map (word offsets on `reg_addr`):
  - 0x00 reads the raw request inputs before masking.
  - 0x01 reads the IRQ-class active set, which is raw AND enable AND NOT class.
  - 0x02 reads the fast-class active set, which is raw AND enable AND class.
  - 0x03 is the enable mask, 0x04 the class bits (1 = fast), 0x05 the vector address and 0x06 the default address.
  - 0x40+k is the control word of slot k, and 0x80+k is the handler address of slot k.
- R3: `fiq_o` is the OR of the enabled fast-class requests. A fast-class source never asserts `irq_o` and never selects a vector.
- R4: With no level in service, `irq_o` is the OR of all enabled IRQ-class requests, whether a slot claims them or not.
- R5: In the slot control word, bit 5 enables the slot and bits 4:0 hold the source index. A slot that is disabled, or whose source is masked or fast-class, never matches. A source that no enabled slot claims is non-vectored.
- R6: A read at 0x05 returns the handler address of the lowest-numbered slot that matches and is not held off.
- R7: A read at 0x05 returns the default address when no slot qualifies.
- R8: When one source is assigned to several enabled slots, the lowest-numbered of those slots takes it.
- R9: A read at 0x05 while `irq_o` is 1 records the served level. The level is the slot number, or the non-vectored level if the default address was returned. Slots at or below that level, and non-vectored requests, are then held off from `irq_o` and from vector selection. A higher slot still asserts `irq_o`.
- R10: Any write at 0x05 releases the recorded level, and all requests become eligible again.
- R11: A read at 0x05 while `irq_o` is 0 leaves the recorded level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | N_SRC | Level interrupt requests, one per source |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read, when `reg_sel` is 1 |
| reg_addr | input | 8 | Word offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | IRQ line to the processor |
| fiq_o | output | 1 | Fast-interrupt line to the processor |

## Verification
The bench programs a slot table in which no two slots share a source, then sweeps every single-source request under three setups: all sources enabled, a checkerboard class split, and a checkerboard mask. These sweeps separate vectored, non-vectored, masked and fast-class sources. Every pair of slot-bound sources is then raised together, which confirms that the lower slot always wins the vector, whatever the source numbers. Targeted sequences cover a duplicated source, a disabled slot, nested holds with higher and lower slots arriving during service, a hold at the non-vectored level, and a vector read with the line idle. Each of these either changes the winner or changes `irq_o` relative to the plain OR.

// File: rtl/vic_pkg.sv
// Package: register word offsets shared by the controller and its users.
// Assumes 8-bit word addressing on the register port.
package vic_pkg;
    localparam logic [7:0] ADDR_RAW      = 8'h00;
    localparam logic [7:0] ADDR_IRQ_STAT = 8'h01;
    localparam logic [7:0] ADDR_FIQ_STAT = 8'h02;
    localparam logic [7:0] ADDR_ENABLE   = 8'h03;
    localparam logic [7:0] ADDR_CLASS    = 8'h04;
    localparam logic [7:0] ADDR_VECTOR   = 8'h05;
    localparam logic [7:0] ADDR_DEFAULT  = 8'h06;
    localparam logic [7:0] ADDR_CTL_BASE = 8'h40;
    localparam logic [7:0] ADDR_HND_BASE = 8'h80;
endpackage

// File: rtl/vic_slot_match.sv
// Slot matcher: flags each slot whose enabled source is actively requesting,
// and marks every source that some enabled slot claims.
// Assumes the source index of each slot is packed SRC_W bits per slot.
module vic_slot_match #(
    parameter int N_SRC  = 32,
    parameter int N_SLOT = 16,
    parameter int SRC_W  = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        irq_act,
    input  logic [N_SLOT-1:0]       slot_en,
    input  logic [N_SLOT*SRC_W-1:0] slot_src,
    output logic [N_SLOT-1:0]       slot_hit,
    output logic [N_SRC-1:0]        vec_src
);
    // One comparator per slot: enabled and its source is active.
    for (genvar k = 0; k < N_SLOT; k++) begin : g_hit
        assign slot_hit[k] = slot_en[k] & irq_act[slot_src[k*SRC_W +: SRC_W]];
    end

    // Collect the set of sources claimed by any enabled slot.
    always_comb begin
        vec_src = '0;
        for (int k = 0; k < N_SLOT; k++) begin
            if (slot_en[k]) vec_src[slot_src[k*SRC_W +: SRC_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/vic_prio_pick.sv
// Fixed-priority picker: returns the lowest set index of the request vector.
// Assumes index 0 is the highest priority.
module vic_prio_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Scan from lowest priority up so the lowest index is written last.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                valid = 1'b1;
                idx   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/vic_prio_ctrl.sv
// Vectored interrupt priority controller top level.
// Holds the configuration registers and the served-priority level, resolves
// the fast and IRQ lines and selects the vector address.
// Assumes: level requests synchronous to clk, DATA_W >= N_SRC,
// and DATA_W > SRC_W so the slot enable bit fits in a data word.
module vic_prio_ctrl #(
    parameter int N_SRC  = 32,
    parameter int N_SLOT = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    import vic_pkg::*;

    localparam int SRC_W   = $clog2(N_SRC);
    localparam int SLOT_IW = $clog2(N_SLOT);
    localparam int LVL_W   = $clog2(N_SLOT + 2);
    localparam logic [LVL_W-1:0] LVL_DEF  = LVL_W'(N_SLOT);
    localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(N_SLOT + 1);

    logic [N_SRC-1:0]              en_q, fast_q;
    logic [DATA_W-1:0]             def_q;
    logic [N_SLOT-1:0]             slot_en_q;
    logic [N_SLOT-1:0][SRC_W-1:0]  slot_src_q;
    logic [N_SLOT-1:0][DATA_W-1:0] hnd_q;
    logic [LVL_W-1:0]              lvl_q;

    logic wr_en, rd_en, rd_vec, wr_vec;
    logic [7:0] ctl_off, hnd_off;
    logic ctl_hit, hnd_hit;
    logic [SLOT_IW-1:0] ctl_idx, hnd_idx;

    logic [N_SRC-1:0]        irq_act, fiq_act, vec_src;
    logic [N_SLOT*SRC_W-1:0] slot_src_flat;
    logic [N_SLOT-1:0]       slot_hit, elig;
    logic                    win_valid;
    logic [SLOT_IW-1:0]      win_idx;
    logic                    nonvec_req;

    // Access decode for the register port.
    assign wr_en   = reg_sel & reg_wr;
    assign rd_en   = reg_sel & ~reg_wr;
    assign rd_vec  = rd_en & (reg_addr == ADDR_VECTOR);
    assign wr_vec  = wr_en & (reg_addr == ADDR_VECTOR);
    assign ctl_off = reg_addr - ADDR_CTL_BASE;
    assign hnd_off = reg_addr - ADDR_HND_BASE;
    assign ctl_hit = ctl_off < 8'(N_SLOT);
    assign hnd_hit = hnd_off < 8'(N_SLOT);
    assign ctl_idx = ctl_off[SLOT_IW-1:0];
    assign hnd_idx = hnd_off[SLOT_IW-1:0];

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            fast_q     <= '0;
            def_q      <= '0;
            slot_en_q  <= '0;
            slot_src_q <= '0;
            hnd_q      <= '0;
        end else if (wr_en) begin
            if (ctl_hit) begin
                slot_en_q[ctl_idx]  <= reg_wdata[SRC_W];
                slot_src_q[ctl_idx] <= reg_wdata[SRC_W-1:0];
            end else if (hnd_hit) begin
                hnd_q[hnd_idx] <= reg_wdata;
            end else begin
                case (reg_addr)
                    ADDR_ENABLE:  en_q   <= reg_wdata[N_SRC-1:0];
                    ADDR_CLASS:   fast_q <= reg_wdata[N_SRC-1:0];
                    ADDR_DEFAULT: def_q  <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Request gating into the two classes.
    assign irq_act = src_req & en_q & ~fast_q;
    assign fiq_act = src_req & en_q & fast_q;
    assign fiq_o   = |fiq_act;

    // Flatten slot source indices for the matcher.
    always_comb begin
        for (int k = 0; k < N_SLOT; k++) slot_src_flat[k*SRC_W +: SRC_W] = slot_src_q[k];
    end

    vic_slot_match #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .SRC_W(SRC_W)) u_match (
        .irq_act  (irq_act),
        .slot_en  (slot_en_q),
        .slot_src (slot_src_flat),
        .slot_hit (slot_hit),
        .vec_src  (vec_src)
    );

    // A slot is eligible only if it ranks above the level in service.
    for (genvar k = 0; k < N_SLOT; k++) begin : g_elig
        assign elig[k] = slot_hit[k] & (LVL_W'(k) < lvl_q);
    end

    vic_prio_pick #(.N(N_SLOT), .IW(SLOT_IW)) u_pick (
        .req   (elig),
        .valid (win_valid),
        .idx   (win_idx)
    );

    // IRQ line: eligible vectored winner or an unheld non-vectored request.
    assign nonvec_req = |(irq_act & ~vec_src);
    assign irq_o      = win_valid | (nonvec_req & (lvl_q > LVL_DEF));

    // Served-level tracking: latch on vector read, release on vector write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_IDLE;
        end else if (wr_vec) begin
            lvl_q <= LVL_IDLE;
        end else if (rd_vec && irq_o) begin
            lvl_q <= win_valid ? LVL_W'(win_idx) : LVL_DEF;
        end
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (ctl_hit) begin
            reg_rdata = DATA_W'({slot_en_q[ctl_idx], slot_src_q[ctl_idx]});
        end else if (hnd_hit) begin
            reg_rdata = hnd_q[hnd_idx];
        end else begin
            case (reg_addr)
                ADDR_RAW:      reg_rdata = DATA_W'(src_req);
                ADDR_IRQ_STAT: reg_rdata = DATA_W'(irq_act);
                ADDR_FIQ_STAT: reg_rdata = DATA_W'(fiq_act);
                ADDR_ENABLE:   reg_rdata = DATA_W'(en_q);
                ADDR_CLASS:    reg_rdata = DATA_W'(fast_q);
                ADDR_VECTOR:   reg_rdata = win_valid ? hnd_q[win_idx] : def_q;
                ADDR_DEFAULT:  reg_rdata = def_q;
                default:       reg_rdata = '0;
            endcase
        end
    end

    // With no IRQ-class request active, the IRQ line must be low.
    assert_fast_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_act == '0) |-> !irq_o);

    // The picked slot is eligible and no higher-ranked slot is.
    assert_lowest_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (elig[win_idx] && ((elig & ((N_SLOT'(1) << win_idx) - N_SLOT'(1))) == '0)));

    // A vector read with the line up records some level.
    assert_latch_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && irq_o) |=> (lvl_q != LVL_IDLE));

    // A vector write always returns to idle.
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vec |=> (lvl_q == LVL_IDLE));

    // A vector read with the line down changes nothing.
    assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && !irq_o) |=> $stable(lvl_q));
endmodule

// File: tb/vic_prio_ctrl_test.sv
`timescale 1ns/1ps
module vic_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, fiq_o;

    int total = 0;
    int bad = 0;

    // Bench-side model of the programmed configuration.
    logic [31:0] m_en = '0, m_fast = '0, m_def = '0;
    bit          m_sen [16];
    int          m_ssrc [16];
    logic [31:0] m_hnd [16];
    int          m_lvl = 17;

    vic_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #2.5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not end (actual hung, expected done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
        #1;
    endtask

    function automatic int exp_slot(logic [31:0] raw);
        logic [31:0] act = raw & m_en & ~m_fast;
        for (int k = 0; k < 16; k++)
            if (m_sen[k] && act[m_ssrc[k]] && k < m_lvl) return k;
        return -1;
    endfunction

    function automatic bit exp_nonvec(logic [31:0] raw);
        logic [31:0] act = raw & m_en & ~m_fast;
        for (int s = 0; s < 32; s++) begin
            bit claimed = 0;
            for (int k = 0; k < 16; k++) if (m_sen[k] && m_ssrc[k] == s) claimed = 1;
            if (act[s] && !claimed) return 1;
        end
        return 0;
    endfunction

    function automatic bit exp_irq(logic [31:0] raw);
        return (exp_slot(raw) >= 0) || (exp_nonvec(raw) && m_lvl > 16);
    endfunction

    task automatic set_slot(input int k, input bit en, input int s);
        m_sen[k] = en; m_ssrc[k] = s;
        wr(8'h40 + 8'(k), {26'd0, en, 5'(s)});
    endtask

    task automatic drive(input logic [31:0] raw, input string req);
        @(negedge clk);
        src_req = raw;
        #1 chk(req, {31'd0, irq_o}, {31'd0, exp_irq(raw)});
    endtask

    task automatic vec_read(input string req);
        logic [31:0] d;
        int sl = exp_slot(src_req);
        logic [31:0] ev = (sl >= 0) ? m_hnd[sl] : m_def;
        bit up = exp_irq(src_req);
        rd(8'h05, d);
        chk(req, d, ev);
        if (up) m_lvl = (sl >= 0) ? sl : 16;
        chk(req, {31'd0, irq_o}, {31'd0, exp_irq(src_req)});
    endtask

    task automatic release_lvl;
        wr(8'h05, 32'h0);
        m_lvl = 17;
    endtask

    task automatic pattern(input logic [31:0] raw, input string req);
        logic [31:0] d;
        drive(raw, "R4");
        chk("R3", {31'd0, fiq_o}, {31'd0, |(raw & m_en & m_fast)});
        rd(8'h00, d); chk("R2", d, raw);
        rd(8'h01, d); chk("R2", d, raw & m_en & ~m_fast);
        rd(8'h02, d); chk("R2", d, raw & m_en & m_fast);
        vec_read(req);
        release_lvl();
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", {30'd0, irq_o, fiq_o}, 32'd0);
        rd(8'h03, d); chk("R1", d, 32'd0);
        rd(8'h04, d); chk("R1", d, 32'd0);
        rd(8'h06, d); chk("R1", d, 32'd0);
        for (int k = 0; k < 16; k++) begin
            rd(8'h40 + 8'(k), d); chk("R1", d, 32'd0);
            rd(8'h80 + 8'(k), d); chk("R1", d, 32'd0);
        end

        // Program: distinct sources, computed handler addresses.
        m_def = 32'hDEAD_0000; wr(8'h06, m_def);
        for (int k = 0; k < 16; k++) begin
            m_hnd[k] = 32'h1000 + 32'(k) * 32'h40;
            wr(8'h80 + 8'(k), m_hnd[k]);
            set_slot(k, 1'b1, (3 * k + 1) % 32);
        end
        rd(8'h45, d); chk("R5", d, 32'h30);
        m_en = '1; wr(8'h03, m_en);

        // R6 R7: single-source sweep, everything enabled.
        for (int s = 0; s < 32; s++) pattern(32'd1 << s, "R6");

        // R3: checkerboard class split.
        m_fast = 32'hF0F0_F0F0; wr(8'h04, m_fast);
        for (int s = 0; s < 32; s++) pattern(32'd1 << s, "R3");
        m_fast = '0; wr(8'h04, m_fast);

        // R5: checkerboard mask.
        m_en = 32'h5555_5555; wr(8'h03, m_en);
        for (int s = 0; s < 32; s++) pattern(32'd1 << s, "R5");
        m_en = '1; wr(8'h03, m_en);

        // R6: every pair of slot-bound sources.
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++)
                pattern((32'd1 << m_ssrc[i]) | (32'd1 << m_ssrc[j]), "R6");

        // R8: duplicated source, lowest slot takes it.
        set_slot(2, 1'b1, m_ssrc[7]);
        pattern(32'd1 << m_ssrc[7], "R8");
        set_slot(2, 1'b1, 7);

        // R5: disabled slot 0, its source becomes non-vectored.
        set_slot(0, 1'b0, 1);
        pattern(32'd1 << 1, "R5");
        set_slot(0, 1'b1, 1);

        // R9 R10: hold and release sequence.
        drive(32'd1 << 16, "R4");
        vec_read("R9");
        chk("R9", {31'd0, irq_o}, 32'd0);
        drive((32'd1 << 16) | (32'd1 << 25), "R9");
        drive((32'd1 << 16) | (32'd1 << 25) | (32'd1 << 10), "R9");
        chk("R9", {31'd0, irq_o}, 32'd1);
        vec_read("R9");
        chk("R9", {31'd0, irq_o}, 32'd0);
        release_lvl();
        #1 chk("R10", {31'd0, irq_o}, 32'd1);
        vec_read("R10");
        release_lvl();

        // R9: hold at the non-vectored level.
        drive(32'd1, "R4");
        vec_read("R9");
        chk("R9", {31'd0, irq_o}, 32'd0);
        drive(32'd1 | (32'd1 << 16), "R9");
        chk("R9", {31'd0, irq_o}, 32'd1);
        vec_read("R9");
        release_lvl();

        // R11: vector read with the line idle does not latch.
        drive(32'd0, "R11");
        vec_read("R11");
        drive(32'd1, "R11");
        chk("R11", {31'd0, irq_o}, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule